// File: doc/BRIEF.md
# CPU Address Window Decoder

This block maps a CPU physical address onto one of several target units through a bank of programmable address windows, eight by default. Each window has a control word, a base, a low remap word and a high remap word, all held in flops and written over a simple single-cycle register bus. The same bus reads them back combinationally. The control word holds the enable flag, the target identifier, the target attribute and a size mask. The size mask is thermometer coded in 64 KB units.

For every address presented on `cpu_addr`, the block compares the address against all enabled windows in parallel. The lowest-numbered enabled window that matches wins. The block then reports that window's index, its target and attribute, and the translated address, and raises a hit flag. When no window matches, it raises a miss flag. The decode path is purely combinational from the address and the current register contents.

Register addressing uses `reg_addr = {window, select}`. The two-bit select picks one of four registers:

- 0: control. Bit 0 is the enable flag, bits 7:4 the target, bits 15:8 the attribute and bits 31:16 the size field. Bits 3:1 are not stored.
- 1: base. Only bits 31:16 are stored.
- 2: low remap. Only bits 31:16 are stored.
- 3: high remap. All 32 bits are stored, and the word does not take part in decoding.

Top module: `addr_window_decoder`

## Requirements
- R1: After reset every window is disabled: every address misses, and every register reads back as zero.
- R2: Register writes are captured on the clock edge and read back with the layout given above. Control bits 3:1 read as zero, the low 16 bits of base and low remap read as zero, and the high remap word reads back in full.
- R3: A window whose enable bit is 0 never matches, even when the address lies inside its range.
- R4: A size field of k contiguous ones starting at bit 0 gives a window of 2^k times 64 KB. A field of 0 gives 64 KB and a field of 0x00FF gives 16 MB. The window is matched on the address bits above bit 15 that lie outside the mask, compared with the base, and the first address past either end misses.
- R5: A size field whose ones are not contiguous acts as its longest run of ones starting at bit 0. For example, 0x00F3 acts as 0x0003, which is 256 KB.
- R6: On a hit, bits 31:16 of the translated address take the low remap bits where the mask is 0 and the input bits where the mask is 1. The low 16 bits always pass through unchanged. When the low remap equals the base, the output equals the input. The high remap word has no effect on the result.
- R7: When several enabled windows match, the lowest-numbered one wins. A change to the registers alters the decode as soon as the write edge has passed.
- R8: Exactly one of the hit and miss flags is high at all times. On a miss, the window index, target, attribute and translated address are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 5 | {window index, register select} |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Combinational readback of the addressed register |
| cpu_addr | input | 32 | Address to decode |
| dec_hit | output | 1 | An enabled window matched |
| dec_miss | output | 1 | No window matched |
| dec_win | output | 3 | Index of the winning window |
| dec_target | output | 4 | Target identifier of the winning window |
| dec_attr | output | 8 | Attribute of the winning window |
| dec_addr | output | 32 | Translated address |

## Verification
The assertions assume that the register-bus inputs and `cpu_addr` hold known values after reset and change only between clock edges. The readback checks on the high remap word also assume that `reg_addr` keeps its value across the edge that follows a write, because the property only compares the readback while it still addresses the register just written. The bench drives every input on the falling edge and never releases any input to an unknown value. It sets up each overlap, mask shape and remap case through ordinary register writes before it presents the addresses to decode.

// File: rtl/addr_window_decoder.sv
module addr_window_decoder #(
  parameter int NUM_WIN   = 8,
  parameter int ADDR_W    = 32,
  parameter int PAGE_BITS = 16,
  parameter int TGT_W     = 4,
  parameter int ATTR_W    = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       reg_wr_en,
  input  logic [$clog2(NUM_WIN)+1:0] reg_addr,
  input  logic [ADDR_W-1:0]          reg_wdata,
  output logic [ADDR_W-1:0]          reg_rdata,
  input  logic [ADDR_W-1:0]          cpu_addr,
  output logic                       dec_hit,
  output logic                       dec_miss,
  output logic [$clog2(NUM_WIN)-1:0] dec_win,
  output logic [TGT_W-1:0]           dec_target,
  output logic [ATTR_W-1:0]          dec_attr,
  output logic [ADDR_W-1:0]          dec_addr
);
  localparam int WIN_W    = $clog2(NUM_WIN);
  localparam int RA_W     = WIN_W + 2;
  localparam int UP_W     = ADDR_W - PAGE_BITS;
  localparam int TGT_LSB  = 4;
  localparam int ATTR_LSB = TGT_LSB + TGT_W;

  logic [NUM_WIN-1:0] en_q;
  logic [TGT_W-1:0]   tgt_q  [NUM_WIN];
  logic [ATTR_W-1:0]  attr_q [NUM_WIN];
  logic [UP_W-1:0]    size_q [NUM_WIN];
  logic [UP_W-1:0]    base_q [NUM_WIN];
  logic [UP_W-1:0]    rlo_q  [NUM_WIN];
  logic [ADDR_W-1:0]  rhi_q  [NUM_WIN];

  logic [UP_W-1:0]    mask   [NUM_WIN];
  logic [ADDR_W-1:0]  xl     [NUM_WIN];
  logic [NUM_WIN-1:0] match;

  wire [WIN_W-1:0] wsel  = reg_addr[RA_W-1:2];
  wire [1:0]       rsel  = reg_addr[1:0];
  wire [UP_W-1:0]  a_up  = cpu_addr[ADDR_W-1:PAGE_BITS];

  function automatic logic [UP_W-1:0] prefix_ones(input logic [UP_W-1:0] s);
    logic run;
    run = 1'b1;
    for (int i = 0; i < UP_W; i++) begin
      run = run & s[i];
      prefix_ones[i] = run;
    end
  endfunction

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        en_q[w]   <= 1'b0;
        tgt_q[w]  <= '0;
        attr_q[w] <= '0;
        size_q[w] <= '0;
        base_q[w] <= '0;
        rlo_q[w]  <= '0;
        rhi_q[w]  <= '0;
      end else if (reg_wr_en && wsel == WIN_W'(w)) begin
        case (rsel)
          2'd0: begin
            en_q[w]   <= reg_wdata[0];
            tgt_q[w]  <= reg_wdata[TGT_LSB +: TGT_W];
            attr_q[w] <= reg_wdata[ATTR_LSB +: ATTR_W];
            size_q[w] <= reg_wdata[ADDR_W-1 -: UP_W];
          end
          2'd1: base_q[w] <= reg_wdata[ADDR_W-1 -: UP_W];
          2'd2: rlo_q[w]  <= reg_wdata[ADDR_W-1 -: UP_W];
          default: rhi_q[w] <= reg_wdata;
        endcase
      end
    end

    assign mask[w]  = prefix_ones(size_q[w]);
    assign match[w] = en_q[w] && (((a_up ^ base_q[w]) & ~mask[w]) == '0);
    assign xl[w]    = {(rlo_q[w] & ~mask[w]) | (a_up & mask[w]),
                       cpu_addr[PAGE_BITS-1:0]};
  end

  always_comb begin
    dec_hit = 1'b0;
    dec_win = '0;
    for (int i = NUM_WIN - 1; i >= 0; i--) begin
      if (match[i]) begin
        dec_hit = 1'b1;
        dec_win = WIN_W'(i);
      end
    end
  end

  assign dec_miss   = ~dec_hit;
  assign dec_target = dec_hit ? tgt_q[dec_win]  : '0;
  assign dec_attr   = dec_hit ? attr_q[dec_win] : '0;
  assign dec_addr   = dec_hit ? xl[dec_win]     : '0;

  always_comb begin
    reg_rdata = '0;
    case (rsel)
      2'd0: begin
        reg_rdata[0]                    = en_q[wsel];
        reg_rdata[TGT_LSB +: TGT_W]     = tgt_q[wsel];
        reg_rdata[ATTR_LSB +: ATTR_W]   = attr_q[wsel];
        reg_rdata[ADDR_W-1 -: UP_W]     = size_q[wsel];
      end
      2'd1: reg_rdata[ADDR_W-1 -: UP_W] = base_q[wsel];
      2'd2: reg_rdata[ADDR_W-1 -: UP_W] = rlo_q[wsel];
      default: reg_rdata = rhi_q[wsel];
    endcase
  end
endmodule

module addr_window_decoder_chk #(
  parameter int ADDR_W    = 32,
  parameter int PAGE_BITS = 16,
  parameter int RA_W      = 5,
  parameter int WIN_W     = 3,
  parameter int TGT_W     = 4,
  parameter int ATTR_W    = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr_en,
  input logic [RA_W-1:0]   reg_addr,
  input logic [ADDR_W-1:0] reg_wdata,
  input logic [ADDR_W-1:0] reg_rdata,
  input logic [ADDR_W-1:0] cpu_addr,
  input logic              dec_hit,
  input logic              dec_miss,
  input logic [WIN_W-1:0]  dec_win,
  input logic [TGT_W-1:0]  dec_target,
  input logic [ATTR_W-1:0] dec_attr,
  input logic [ADDR_W-1:0] dec_addr
);
  // R8
  hit_miss_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dec_hit != dec_miss);

  // R8
  miss_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dec_miss |-> (dec_win == '0 && dec_target == '0 && dec_attr == '0 && dec_addr == '0));

  // R6
  low_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dec_hit |-> dec_addr[PAGE_BITS-1:0] == cpu_addr[PAGE_BITS-1:0]);

  // R2
  rhi_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr_en && reg_addr[1:0] == 2'd3) |=>
      (reg_addr != $past(reg_addr) || reg_rdata == $past(reg_wdata)));

  // R2
  page_low_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr[1:0] == 2'd1 || reg_addr[1:0] == 2'd2) |-> reg_rdata[PAGE_BITS-1:0] == '0);
endmodule

bind addr_window_decoder addr_window_decoder_chk #(
  .ADDR_W(ADDR_W), .PAGE_BITS(PAGE_BITS), .RA_W(RA_W), .WIN_W(WIN_W),
  .TGT_W(TGT_W), .ATTR_W(ATTR_W)
) chk_i (
  .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cpu_addr(cpu_addr),
  .dec_hit(dec_hit), .dec_miss(dec_miss), .dec_win(dec_win),
  .dec_target(dec_target), .dec_attr(dec_attr), .dec_addr(dec_addr)
);

// File: tb/addr_window_decoder_tb.sv
module addr_window_decoder_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr_en = 1'b0;
  logic [4:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [31:0] cpu_addr = '0;
  logic        dec_hit, dec_miss;
  logic [2:0]  dec_win;
  logic [3:0]  dec_target;
  logic [7:0]  dec_attr;
  logic [31:0] dec_addr;

  int n_cmp = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  addr_window_decoder dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cpu_addr(cpu_addr),
    .dec_hit(dec_hit), .dec_miss(dec_miss), .dec_win(dec_win),
    .dec_target(dec_target), .dec_attr(dec_attr), .dec_addr(dec_addr)
  );

  function automatic logic [31:0] mk_ctrl(input bit en, input logic [3:0] tgt,
                                          input logic [7:0] attr, input logic [15:0] size);
    return {size, attr, tgt, 3'b000, en};
  endfunction

  task automatic wr(input int w, input int sel, input logic [31:0] d);
    @(negedge clk);
    reg_wr_en = 1'b1;
    reg_addr  = {w[2:0], sel[1:0]};
    reg_wdata = d;
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic chk_rd(input int w, input int sel, input logic [31:0] exp, input string tag);
    @(negedge clk);
    reg_addr = {w[2:0], sel[1:0]};
    #1;
    n_cmp++;
    if (reg_rdata !== exp) begin
      n_bad++;
      $display("FAIL %s: readback win%0d sel%0d got %h exp %h", tag, w, sel, reg_rdata, exp);
    end
  endtask

  task automatic chk_dec(input logic [31:0] a, input bit eh, input logic [2:0] ew,
                         input logic [3:0] et, input logic [7:0] ea,
                         input logic [31:0] ex, input string tag);
    @(negedge clk);
    cpu_addr = a;
    #1;
    n_cmp++;
    if (dec_hit !== eh || dec_miss !== !eh || dec_win !== ew || dec_target !== et ||
        dec_attr !== ea || dec_addr !== ex) begin
      n_bad++;
      $display("FAIL %s: addr %h got hit=%b miss=%b win=%0d tgt=%h attr=%h out=%h exp hit=%b win=%0d tgt=%h attr=%h out=%h",
               tag, a, dec_hit, dec_miss, dec_win, dec_target, dec_attr, dec_addr,
               eh, ew, et, ea, ex);
    end
  endtask

  task automatic t_reset;
    chk_rd(0, 0, 32'h0, "R1");
    chk_rd(3, 1, 32'h0, "R1");
    chk_rd(7, 3, 32'h0, "R1");
    chk_dec(32'h0000_0000, 0, 0, 0, 0, 0, "R1");
    chk_dec(32'hFFFF_1234, 0, 0, 0, 0, 0, "R1 R8");
  endtask

  task automatic t_regs;
    wr(2, 0, 32'h00FF_AB5F);
    chk_rd(2, 0, 32'h00FF_AB51, "R2 ctrl");
    wr(2, 1, 32'h1234_5678);
    chk_rd(2, 1, 32'h1234_0000, "R2 base");
    wr(2, 2, 32'h8765_4321);
    chk_rd(2, 2, 32'h8765_0000, "R2 remap low");
    wr(2, 3, 32'hDEAD_BEEF);
    chk_rd(2, 3, 32'hDEAD_BEEF, "R2 remap high");
    wr(2, 0, 32'h0);
    chk_rd(2, 0, 32'h0, "R2 clear");
  endtask

  task automatic t_disabled;
    wr(1, 1, 32'h4000_0000);
    wr(1, 2, 32'h4000_0000);
    wr(1, 0, mk_ctrl(0, 4'h3, 8'h11, 16'h00FF));
    chk_dec(32'h4012_3456, 0, 0, 0, 0, 0, "R3");
    wr(1, 0, mk_ctrl(1, 4'h3, 8'h11, 16'h00FF));
    chk_dec(32'h4012_3456, 1, 1, 4'h3, 8'h11, 32'h4012_3456, "R3 R6 identity");
  endtask

  task automatic t_size;
    chk_dec(32'h40FF_FFFF, 1, 1, 4'h3, 8'h11, 32'h40FF_FFFF, "R4 16MB top");
    chk_dec(32'h4100_0000, 0, 0, 0, 0, 0, "R4 16MB past end");
    chk_dec(32'h3FFF_FFFF, 0, 0, 0, 0, 0, "R4 16MB below");
    wr(0, 1, 32'h8000_0000);
    wr(0, 2, 32'h8000_0000);
    wr(0, 0, mk_ctrl(1, 4'h1, 8'h22, 16'h0000));
    chk_dec(32'h8000_FFFF, 1, 0, 4'h1, 8'h22, 32'h8000_FFFF, "R4 64KB top");
    chk_dec(32'h8001_0000, 0, 0, 0, 0, 0, "R4 64KB past end");
  endtask

  task automatic t_noncontig;
    wr(3, 1, 32'h9000_0000);
    wr(3, 2, 32'h9000_0000);
    wr(3, 0, mk_ctrl(1, 4'h6, 8'h44, 16'h00F3));
    chk_dec(32'h9003_FFFF, 1, 3, 4'h6, 8'h44, 32'h9003_FFFF, "R5 prefix top");
    chk_dec(32'h9004_0000, 0, 0, 0, 0, 0, "R5 past prefix");
    chk_dec(32'h9010_0000, 0, 0, 0, 0, 0, "R5 stray bit ignored");
  endtask

  task automatic t_remap;
    wr(4, 1, 32'hA000_0000);
    wr(4, 2, 32'h1230_0000);
    wr(4, 0, mk_ctrl(1, 4'h7, 8'h3C, 16'h000F));
    chk_dec(32'hA00A_BCDE, 1, 4, 4'h7, 8'h3C, 32'h123A_BCDE, "R6 remap");
    wr(4, 2, 32'h123F_0000);
    chk_dec(32'hA00A_BCDE, 1, 4, 4'h7, 8'h3C, 32'h123A_BCDE, "R6 masked remap bits");
    wr(4, 3, 32'hFFFF_FFFF);
    chk_dec(32'hA005_0001, 1, 4, 4'h7, 8'h3C, 32'h1235_0001, "R6 high word inert");
  endtask

  task automatic t_priority;
    wr(5, 1, 32'hA000_0000);
    wr(5, 2, 32'hB000_0000);
    wr(5, 0, mk_ctrl(1, 4'h9, 8'h55, 16'h00FF));
    chk_dec(32'hA00A_0000, 1, 4, 4'h7, 8'h3C, 32'h123A_0000, "R7 lower wins");
    chk_dec(32'hA050_1234, 1, 5, 4'h9, 8'h55, 32'hB050_1234, "R7 only upper");
    wr(4, 0, 32'h0);
    chk_dec(32'hA00A_0000, 1, 5, 4'h9, 8'h55, 32'hB00A_0000, "R7 after disable");
  endtask

  initial begin
    #(8 * 200000);
    n_bad++;
    $display("FAIL watchdog: run did not finish, got timeout exp completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset;
    t_regs;
    t_disabled;
    t_size;
    t_noncontig;
    t_remap;
    t_priority;
    repeat (2) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule